// File: doc/BRIEF.md
# Prescaled Compare Timer with Interrupt

This block is a free-running timer that a processor drives through a small word-wide register port. An adjustable divider turns the system clock into count ticks, and every tick advances an up-counter that is 24 bits wide by default. When the counter reaches the value in a compare register, a sticky flag is set. The counter keeps running through that match. An interrupt line presents the flag, gated by an enable bit.

Firmware starts and stops counting with a run bit. After a start it polls an active bit, which shows that counting has really begun. It reads the live count at any time. It can also move the compare point while the timer runs without upsetting the count. Compare values outside the legal window are clamped when they are written. The smallest legal value is 2, so a requested interval shorter than that fires a little late.

The port is a single write strobe with a 2-bit word address. Read data is registered: the word selected in one cycle appears after the next rising edge. Word 0 is control and status: bit 0 run, bit 1 interrupt enable, bits 14:8 divider setting, bit 16 active (read-only). Word 1 is the compare value. Word 2 is the counter (read-only). Word 3 holds the flag at bit 0.

Top module: `cmp_timer`

## Requirements
- R1: The counter is CNT_W bits (24 by default) and steps from all-ones back to zero on the next tick.
- R2: With the divider field at bits 14:8 of word 0 set to N, a tick occurs every N+1 clocks while running. The counter changes only on a tick, or when a restart clears it.
- R3: When a tick takes the counter to the compare value, the flag (word 3 bit 0) is set and the counter keeps counting upward without reloading.
- R4: A write to the compare word (word 1) leaves the counter value untouched.
- R5: Writing run=1 (word 0 bit 0) while stopped clears the counter and the divider. Writing run=1 while already running changes neither.
- R6: A compare write below CMP_MIN (2) stores CMP_MIN, and a write above 2^CNT_W-1 stores 2^CNT_W-1. Any other value is stored as written.
- R7: The flag stays set until a write to word 3 with bit 0 high clears it. If a match falls in the same cycle as the clear, the flag stays set.
- R8: The irq output is high exactly when the flag and the enable bit (word 0 bit 1) are both set.
- R9: The active bit (word 0 bit 16) rises on the first tick after a start. It is clear in the cycle after a stop write, and whenever the timer is stopped.
- R10: Read data shows the word addressed before the latest rising edge. After reset, control reads 0, the compare word reads 2^CNT_W-1, the counter reads 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
The checker assumes that writes are one-cycle strobes with a valid word address. It also assumes that the divider setting is changed only while the timer is stopped, so every tick period is a whole N+1 clocks. The stimulus writes the divider only together with a start, or while the run bit is clear. The bench instantiates a 10-bit counter so that the wrap is reached within a short run. Every address it drives is one of the four defined words.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_FLAG  = 2'd3
  } word_sel_e;

  // bit positions inside the control/status word
  localparam int unsigned BIT_RUN     = 0;
  localparam int unsigned BIT_IE      = 1;
  localparam int unsigned BIT_PSC_LSB = 8;
  localparam int unsigned BIT_ACTIVE  = 16;
  localparam int unsigned BIT_FLAG    = 0;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int unsigned PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;

  assign tick = run && (div_q >= psc);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= div_q + PSC_W'(1);
    end
  end
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign match   = tick && (cnt_inc == cmp);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned PSC_W   = 7,
  parameter int unsigned CMP_MIN = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              tick,
  input  logic              match,
  input  logic [CNT_W-1:0]  cnt,
  output logic              run,
  output logic              restart,
  output logic [PSC_W-1:0]  psc,
  output logic [CNT_W-1:0]  cmp,
  output logic              ie,
  output logic              flag,
  output logic              active,
  output logic              irq,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [DATA_W-1:0] LIM_HI = {{(DATA_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};
  localparam logic [DATA_W-1:0] LIM_LO = DATA_W'(CMP_MIN);

  logic             run_q, ie_q, flag_q, act_q, irq_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cmp_q;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic ctrl_wr, cmp_wr, clr_wr, stop_wr;
  logic flag_d, ie_d;
  logic [CNT_W-1:0] cmp_clamped;

  assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);
  assign cmp_wr  = reg_wr && (reg_addr == SEL_CMP);
  assign clr_wr  = reg_wr && (reg_addr == SEL_FLAG) && reg_wdata[BIT_FLAG];
  assign restart = ctrl_wr && reg_wdata[BIT_RUN] && !run_q;
  assign stop_wr = ctrl_wr && !reg_wdata[BIT_RUN];

  always_comb begin
    if (reg_wdata < LIM_LO)      cmp_clamped = LIM_LO[CNT_W-1:0];
    else if (reg_wdata > LIM_HI) cmp_clamped = LIM_HI[CNT_W-1:0];
    else                         cmp_clamped = reg_wdata[CNT_W-1:0];
  end

  // a match outranks a clear in the same cycle
  assign flag_d = match ? 1'b1 : (clr_wr ? 1'b0 : flag_q);
  assign ie_d   = ctrl_wr ? reg_wdata[BIT_IE] : ie_q;

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      SEL_CTRL: begin
        rd_d[BIT_RUN]               = run_q;
        rd_d[BIT_IE]                = ie_q;
        rd_d[BIT_PSC_LSB +: PSC_W]  = psc_q;
        rd_d[BIT_ACTIVE]            = act_q;
      end
      SEL_CMP:   rd_d[CNT_W-1:0] = cmp_q;
      SEL_COUNT: rd_d[CNT_W-1:0] = cnt;
      default:   rd_d[BIT_FLAG]  = flag_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      psc_q  <= '0;
      cmp_q  <= LIM_HI[CNT_W-1:0];
      flag_q <= 1'b0;
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q <= reg_wdata[BIT_RUN];
        psc_q <= reg_wdata[BIT_PSC_LSB +: PSC_W];
      end
      ie_q <= ie_d;
      if (cmp_wr) cmp_q <= cmp_clamped;
      flag_q <= flag_d;
      if (stop_wr || restart) act_q <= 1'b0;
      else if (tick)          act_q <= 1'b1;
      irq_q <= flag_d && ie_d;
      rd_q  <= rd_d;
    end
  end

  assign run       = run_q;
  assign psc       = psc_q;
  assign cmp       = cmp_q;
  assign ie        = ie_q;
  assign flag      = flag_q;
  assign active    = act_q;
  assign irq       = irq_q;
  assign reg_rdata = rd_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned PSC_W   = 7,
  parameter int unsigned CMP_MIN = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             tick, match, run, restart, ie, flag, active;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cmp, cnt;

  cmp_timer_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .psc(psc), .tick(tick)
  );

  cmp_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart), .cmp(cmp),
    .cnt(cnt), .match(match)
  );

  cmp_timer_regs #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .CMP_MIN(CMP_MIN), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tick(tick), .match(match), .cnt(cnt),
    .run(run), .restart(restart), .psc(psc), .cmp(cmp), .ie(ie),
    .flag(flag), .active(active), .irq(irq), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned CMP_MIN = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             wd0,
  input logic             irq,
  input logic             tick,
  input logic             run,
  input logic             active,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  logic start_req, clr_req;
  assign start_req = reg_wr && (reg_addr == 2'd0) && wd0 && !run;
  assign clr_req   = reg_wr && (reg_addr == 2'd3) && wd0;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == ALL_ONES) |=> (cnt == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start_req) |=> $stable(cnt));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != ALL_ONES) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_cmp_range_R6: assert property (@(posedge clk) disable iff (rst)
    cmp >= CNT_W'(CMP_MIN));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag);

  assert_irq_src_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !run |-> !active);

  assert_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(tick));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .CMP_MIN(CMP_MIN)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd0(reg_wdata[0]), .irq(irq), .tick(tick), .run(run), .active(active),
  .flag(flag), .cnt(cnt), .cmp(cmp)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  localparam int CW   = 10;
  localparam int MAXV = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 0;
  bit live  = 0;

  always #10 clk = ~clk;

  cmp_timer #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference, advanced once per rising edge
  int m_run, m_ie, m_psc, m_cmp, m_cnt, m_div, m_flag, m_act, m_irq;
  logic [31:0] m_rd;
  int rd_n;
  bit tk, hit, cw, startw, stopw, clrw;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_ie = 0; m_psc = 0; m_cmp = MAXV; m_cnt = 0; m_div = 0;
      m_flag = 0; m_act = 0; m_rd = '0; m_irq = 0;
    end else begin
      case (reg_addr)
        2'd0: rd_n = m_run | (m_ie << 1) | (m_psc << 8) | (m_act << 16);
        2'd1: rd_n = m_cmp;
        2'd2: rd_n = m_cnt;
        default: rd_n = m_flag;
      endcase
      tk     = (m_run != 0) && (m_div >= m_psc);
      hit    = tk && (((m_cnt + 1) % (MAXV + 1)) == m_cmp);
      cw     = reg_wr && reg_addr == 2'd0;
      startw = cw && reg_wdata[0] && m_run == 0;
      stopw  = cw && !reg_wdata[0];
      clrw   = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
      if (startw) begin m_cnt = 0; m_div = 0; end
      else if (tk) begin m_cnt = (m_cnt + 1) % (MAXV + 1); m_div = 0; end
      else if (m_run != 0) m_div = m_div + 1;
      if (hit) m_flag = 1; else if (clrw) m_flag = 0;
      if (stopw || startw) m_act = 0; else if (tk) m_act = 1;
      if (cw) begin
        m_run = int'(reg_wdata[0]); m_ie = int'(reg_wdata[1]);
        m_psc = int'(reg_wdata[14:8]);
      end
      if (reg_wr && reg_addr == 2'd1) begin
        if (reg_wdata < 32'd2) m_cmp = 2;
        else if (reg_wdata > 32'(MAXV)) m_cmp = MAXV;
        else m_cmp = int'(reg_wdata);
      end
      m_rd  = 32'(rd_n);
      m_irq = m_flag & m_ie;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (live && !rst) begin
      n_run++;
      if (irq !== m_irq[0]) begin
        n_bad++;
        $display("FAIL R8 cycle irq actual=%0d expected=%0d", irq, m_irq);
      end
      n_run++;
      if (reg_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s cycle rdata actual=%0h expected=%0h",
          reg_addr == 2'd0 ? "R9" : reg_addr == 2'd1 ? "R6" :
          reg_addr == 2'd2 ? "R1" : "R7", reg_rdata, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks begin and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;

    // R10 reset values
    rd(2'd0, v); chk("R10 ctrl after reset", v, 32'h0);
    rd(2'd1, v); chk("R10 cmp after reset", v, 32'(MAXV));
    rd(2'd2, v); chk("R10 count after reset", v, 32'h0);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);

    // R6 clamping
    wr(2'd1, 32'd0);          rd(2'd1, v); chk("R6 clamp 0", v, 32'd2);
    wr(2'd1, 32'd1);          rd(2'd1, v); chk("R6 clamp 1", v, 32'd2);
    wr(2'd1, 32'd3);          rd(2'd1, v); chk("R6 keep 3", v, 32'd3);
    wr(2'd1, 32'h500);        rd(2'd1, v); chk("R6 clamp high", v, 32'(MAXV));
    wr(2'd1, 32'hFFFF_FFFF);  rd(2'd1, v); chk("R6 clamp all-ones", v, 32'(MAXV));

    // R2 divide by 4, 40 clocks -> 10 ticks
    wr(2'd0, 32'h0301);
    idle(39);
    wr(2'd0, 32'h0);
    rd(2'd2, v); chk("R2 ticks at N+1", v, 32'd10);
    idle(5);
    rd(2'd2, v); chk("R2 hold when stopped", v, 32'd10);

    // R5 restart clears counter and divider
    wr(2'd0, 32'h0301);
    rd(2'd2, v); chk("R5 restart clears", v, 32'd0);
    idle(2);
    rd(2'd2, v); chk("R5 divider restarted", v, 32'd0);
    rd(2'd2, v); chk("R5 first tick", v, 32'd1);
    idle(6);
    rd(2'd2, c0);
    wr(2'd0, 32'h0301);
    rd(2'd2, v); chk("R5 start while running keeps count", {31'b0, v >= c0}, 32'd1);
    wr(2'd0, 32'h0);

    // R9 active latency, divide by 6
    wr(2'd0, 32'h0501);
    rd(2'd0, v); chk("R9 active low right after start", {31'b0, v[16]}, 32'd0);
    idle(4);
    rd(2'd0, v); chk("R9 active low before tick", {31'b0, v[16]}, 32'd0);
    rd(2'd0, v); chk("R9 active after first tick", {31'b0, v[16]}, 32'd1);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R9 active drops on stop", {31'b0, v[16]}, 32'd0);

    // R3 / R4 / R8 / R7 match behaviour
    wr(2'd3, 32'h1);
    wr(2'd1, 32'd20);
    wr(2'd0, 32'h0001);
    idle(19);
    rd(2'd3, v); chk("R3 flag before match", v, 32'd0);
    rd(2'd3, v); chk("R3 flag on match", v, 32'd1);
    rd(2'd2, v); chk("R3 count runs past match", v, 32'd21);
    chk("R8 irq masked", {31'b0, irq}, 32'd0);
    wr(2'd1, 32'd500);
    rd(2'd2, v); chk("R4 cmp write keeps count", v, 32'd23);
    wr(2'd0, 32'h0003);
    chk("R8 irq when enabled", {31'b0, irq}, 32'd1);
    idle(10);
    rd(2'd3, v); chk("R7 flag sticky", v, 32'd1);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R7 clear", v, 32'd0);
    chk("R8 irq after clear", {31'b0, irq}, 32'd0);

    // R7 set wins over clear
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd20);
    wr(2'd0, 32'h0001);
    idle(19);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R7 match beats clear", v, 32'd1);

    // R1 wrap
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h1);
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h0001);
    idle(1022);
    rd(2'd2, v); chk("R1 near top", v, 32'(MAXV - 1));
    rd(2'd2, v); chk("R1 at top", v, 32'(MAXV));
    rd(2'd2, v); chk("R1 wrap to zero", v, 32'd0);
    rd(2'd3, v); chk("R6 clamped compare still fires", v, 32'd1);
    wr(2'd0, 32'h0);
    idle(2);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule